// File: doc/BRIEF.md
# Serial ADC Output Port with Power-Mode Decoder

This block is the digital side of a serial sampling converter. A host drives two strobes into it: a conversion strobe and a serial clock. Each rising edge of the conversion strobe starts a new output frame: the block moves the sample captured at the previous strobe into its transmit register and captures the newest word offered by the converter core. The host then clocks out the transmitted word, most significant bit first. The serial data line is not driven during the first two serial clock edges of a frame. It is driven for the next twelve edges and released again before the frame ends.

The same two strobes also select a low-power state. Conversion strobes that arrive back to back, with no serial clock edge between them, are counted. A run of two or three selects nap, and a run of four or more selects sleep. In sleep the captured sample is frozen. Both strobes are synchronous level inputs sampled on the block clock. A registered sample source stands in for the converter core and presents a word with a one-cycle valid flag.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_oe_o`, `hold_o`, `nap_o` and `sleep_o` are all 0.
- R2: A rising edge on `conv_i` sets `hold_o` to 1 and restarts the frame; `sdo_oe_o` stays 0 through the first and second `sck_i` rising edges of the frame.
- R3: From the third to the fourteenth `sck_i` rising edge of a frame, `sdo_oe_o` is 1 and `sdo_o` carries the transmitted word as straight binary, bit 11 after edge 3 down to bit 0 after edge 14.
- R4: From the fifteenth `sck_i` rising edge on, `sdo_oe_o` is 0; `hold_o` returns to 0 at the sixteenth edge, and further `sck_i` edges in that frame change nothing.
- R5: The word sent in a frame is the sample captured at the previous `conv_i` rising edge; each `conv_i` rising edge captures the last word presented with `core_valid_i` = 1 (reset value 0).
- R6: Any number of idle clock cycles between `sck_i` edges leaves the bit sequence unchanged (no timeout).
- R7: A `conv_i` rising edge that makes the run of strobes with no `sck_i` rising edge between them equal to 2 or 3 sets `nap_o` = 1 and `sleep_o` = 0.
- R8: A `conv_i` rising edge that makes that run 4 or more sets `sleep_o` = 1 and `nap_o` = 0.
- R9: An `sck_i` rising edge clears the run count but leaves `nap_o` and `sleep_o` unchanged; the next `conv_i` rising edge (run 1) clears both.
- R10: A `conv_i` rising edge that reaches sleep does not capture a new sample, so the word captured before sleep is kept across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Conversion strobe, synchronous level |
| sck_i | input | 1 | Serial clock from host, synchronous level |
| core_data_i | input | 12 | Sample word from the converter core |
| core_valid_i | input | 1 | Marks `core_data_i` as a new sample |
| sdo_o | output | 1 | Serial data, high-impedance when not enabled |
| sdo_oe_o | output | 1 | Serial data drive enable |
| hold_o | output | 1 | 1 = hold, 0 = track/sample |
| nap_o | output | 1 | Nap power state |
| sleep_o | output | 1 | Sleep power state |

## Verification
Assertions check some rules on every cycle. The data line is enabled only while hold is set, nap and sleep are never both set, the power flags change only on a conversion edge, the enable never changes without a strobe edge, and the captured sample stays put on a conversion edge that enters sleep. The bench scenarios cover what needs a history of strobes. These are the exact bit order within a frame, the one-frame delay between capture and transmission, the effect of long idle gaps between serial clock edges, and the run counting through nap, sleep and wake-up. Sleep wake-up is checked by sending a word captured before sleep.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
   typedef enum logic [1:0] {
      PWR_RUN   = 2'd0,
      PWR_NAP   = 2'd1,
      PWR_SLEEP = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] lvl_q;

   for (genvar g = 0; g < N; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q[g] <= 1'b0;
         else        lvl_q[g] <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
   end
endmodule

// File: rtl/adc_sample_hold.sv
module adc_sample_hold #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] core_data_i,
   input  logic              core_valid_i,
   input  logic              conv_rise_i,
   input  logic              freeze_i,
   output logic [DATA_W-1:0] tx_word_o
);
   logic [DATA_W-1:0] pend_q, cap_q, tx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         cap_q  <= '0;
         tx_q   <= '0;
      end else begin
         if (core_valid_i) pend_q <= core_data_i;
         if (conv_rise_i) begin
            tx_q <= cap_q;
            if (!freeze_i) cap_q <= pend_q;
         end
      end
   end

   assign tx_word_o = tx_q;

   a_r10_sleep_keeps_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_rise_i && freeze_i) |=> $stable(cap_q));
endmodule

// File: rtl/adc_pwr_dec.sv
module adc_pwr_dec
   import adc_serial_pkg::*;
#(
   parameter int NAP_RUN   = 2,
   parameter int SLEEP_RUN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_rise_i,
   input  logic sck_rise_i,
   output logic freeze_o,
   output logic nap_o,
   output logic sleep_o
);
   localparam int RUN_W = $clog2(SLEEP_RUN + 1);

   logic [RUN_W-1:0] run_q, run_nx;
   pwr_state_t       st_q, st_nx;

   always_comb begin
      if (sck_rise_i)                         run_nx = RUN_W'(1);
      else if (run_q == RUN_W'(SLEEP_RUN))    run_nx = run_q;
      else                                    run_nx = run_q + RUN_W'(1);
      if (run_nx >= RUN_W'(SLEEP_RUN))        st_nx = PWR_SLEEP;
      else if (run_nx >= RUN_W'(NAP_RUN))     st_nx = PWR_NAP;
      else                                    st_nx = PWR_RUN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         st_q  <= PWR_RUN;
      end else if (conv_rise_i) begin
         run_q <= run_nx;
         st_q  <= st_nx;
      end else if (sck_rise_i) begin
         run_q <= '0;
      end
   end

   assign freeze_o = conv_rise_i && (st_nx == PWR_SLEEP);
   assign nap_o    = (st_q == PWR_NAP);
   assign sleep_o  = (st_q == PWR_SLEEP);

   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nap_o && sleep_o));
   a_r9_flags_change_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_rise_i |=> ($stable(nap_o) && $stable(sleep_o)));
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
   parameter int DATA_W      = 12,
   parameter int LEAD_EDGES  = 2,
   parameter int FRAME_EDGES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_rise_i,
   input  logic              sck_rise_i,
   input  logic [DATA_W-1:0] tx_word_i,
   output logic              sdo_bit_o,
   output logic              sdo_oe_o,
   output logic              hold_o
);
   localparam int CNT_W = $clog2(FRAME_EDGES + 1);
   localparam int FIRST = LEAD_EDGES + 1;
   localparam int LAST  = LEAD_EDGES + DATA_W;

   logic [CNT_W-1:0]  cnt_q, sh_amt;
   logic              act_q;
   logic [DATA_W-1:0] shifted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (conv_rise_i) begin
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (sck_rise_i && act_q) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == CNT_W'(FRAME_EDGES - 1)) act_q <= 1'b0;
      end
   end

   assign sdo_oe_o  = act_q && (cnt_q >= CNT_W'(FIRST)) && (cnt_q <= CNT_W'(LAST));
   assign sh_amt    = CNT_W'(LAST) - cnt_q;
   assign shifted   = tx_word_i >> sh_amt;
   assign sdo_bit_o = sdo_oe_o & shifted[0];
   assign hold_o    = act_q;

   a_r2_drive_only_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe_o |-> hold_o);
   a_r4_released_before_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> !sdo_oe_o);
   a_r6_enable_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_rise_i && !conv_rise_i) |=> $stable(sdo_oe_o));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
   parameter int DATA_W      = 12,
   parameter int LEAD_EDGES  = 2,
   parameter int FRAME_EDGES = 16,
   parameter int NAP_RUN     = 2,
   parameter int SLEEP_RUN   = 4,
   parameter bit PWR_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_i,
   input  logic              sck_i,
   input  logic [DATA_W-1:0] core_data_i,
   input  logic              core_valid_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              hold_o,
   output logic              nap_o,
   output logic              sleep_o
);
   if (LEAD_EDGES + DATA_W >= FRAME_EDGES) begin : g_bad_frame
      $error("frame too short for lead edges plus data bits");
   end
   if (NAP_RUN < 2 || SLEEP_RUN <= NAP_RUN) begin : g_bad_runs
      $error("power run thresholds out of order");
   end

   logic [1:0]        rise;
   logic              conv_rise, sck_rise, freeze, sdo_bit;
   logic [DATA_W-1:0] tx_word;

   adc_edge_det #(.N(2)) u_edges (
      .clk(clk), .rst_n(rst_n), .lvl_i({sck_i, conv_i}), .rise_o(rise));
   assign conv_rise = rise[0];
   assign sck_rise  = rise[1];

   if (PWR_EN) begin : g_pwr
      adc_pwr_dec #(.NAP_RUN(NAP_RUN), .SLEEP_RUN(SLEEP_RUN)) u_pwr (
         .clk(clk), .rst_n(rst_n), .conv_rise_i(conv_rise), .sck_rise_i(sck_rise),
         .freeze_o(freeze), .nap_o(nap_o), .sleep_o(sleep_o));
   end else begin : g_no_pwr
      assign freeze  = 1'b0;
      assign nap_o   = 1'b0;
      assign sleep_o = 1'b0;
   end

   adc_sample_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .core_data_i(core_data_i), .core_valid_i(core_valid_i),
      .conv_rise_i(conv_rise), .freeze_i(freeze), .tx_word_o(tx_word));

   adc_frame_seq #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES), .FRAME_EDGES(FRAME_EDGES)) u_frame (
      .clk(clk), .rst_n(rst_n), .conv_rise_i(conv_rise), .sck_rise_i(sck_rise),
      .tx_word_i(tx_word), .sdo_bit_o(sdo_bit), .sdo_oe_o(sdo_oe_o), .hold_o(hold_o));

   assign sdo_o = sdo_oe_o ? sdo_bit : 1'bz;
endmodule

// File: tb/adc_serial_port_tb_top.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv = 1'b0, sck = 1'b0, cvalid = 1'b0;
   logic [11:0] cdata = '0;
   wire         sdo;
   logic        sdo_oe, hold, nap, sleep;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // model state
   logic [11:0] m_pend = '0, m_cap = '0, m_tx = '0;
   int          m_run = 0;

   always #2.5 clk = ~clk;

   adc_serial_port dut_i (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
      .core_data_i(cdata), .core_valid_i(cvalid),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold), .nap_o(nap), .sleep_o(sleep));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_frame(input logic [11:0] w, input int k);
      // {hold, oe, data}: data bit 11 at edge 3 down to bit 0 at edge 14
      int h = (k < 16) ? 1 : 0;
      int oe = (k >= 3 && k <= 14) ? 1 : 0;
      int d = oe ? int'(w[14 - k]) : 0;
      return (h << 2) | (oe << 1) | d;
   endfunction

   task automatic load(input logic [11:0] d);
      @(negedge clk); cdata = d; cvalid = 1'b1;
      @(negedge clk); cvalid = 1'b0;
      m_pend = d;
   endtask

   task automatic conv_pulse(input string req);
      @(negedge clk); conv = 1'b1;
      @(negedge clk); conv = 1'b0;
      if (m_run < 4) m_run++;
      m_tx = m_cap;
      if (m_run < 4) m_cap = m_pend;
      chk(nap === ((m_run == 2 || m_run == 3) ? 1'b1 : 1'b0) &&
          sleep === ((m_run >= 4) ? 1'b1 : 1'b0) && hold === 1'b1 && sdo_oe === 1'b0,
          req, {nap, sleep, hold, sdo_oe},
          {((m_run == 2 || m_run == 3) ? 1'b1 : 1'b0), ((m_run >= 4) ? 1'b1 : 1'b0), 2'b10});
   endtask

   task automatic sck_pulse(input int gap);
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sck = 1'b0;
      m_run = 0;
      repeat (gap) @(negedge clk);
   endtask

   function automatic int act_frame();
      return {29'd0, hold, sdo_oe, (sdo_oe ? sdo : 1'b0)};
   endfunction

   // R3 R4 R5 R6: full frame of 16 edges plus extra edges that must change nothing
   task automatic run_frame(input int max_gap, input int extra);
      for (int k = 1; k <= 16 + extra; k++) begin
         int e, kk;
         sck_pulse($urandom_range(max_gap, 0));
         kk = (k > 16) ? 16 : k;
         e = exp_frame(m_tx, kk);
         chk(act_frame() == e, (k <= 2) ? "R2 lead edges" : (k <= 14) ? "R3/R5/R6 data bit" : "R4 tail",
             act_frame(), e);
      end
   endtask

   initial begin
      void'($urandom(32'h5a17));
      repeat (3) @(negedge clk);
      chk(sdo_oe === 1'b0 && hold === 1'b0 && nap === 1'b0 && sleep === 1'b0,
          "R1 reset", {sdo_oe, hold, nap, sleep}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // first frame sends reset value 0 (R5)
      load(12'hA5C);
      conv_pulse("R2 frame start");
      run_frame(0, 0);
      // random frames, random gaps between clock edges (R6)
      for (int f = 0; f < 24; f++) begin
         load(12'($urandom));
         conv_pulse("R5 capture");
         run_frame((f % 4 == 0) ? 40 : 3, (f % 5 == 0) ? 3 : 0);
      end
      // directed corner words
      load(12'hFFF); conv_pulse("R5 capture"); run_frame(0, 0);
      load(12'h001); conv_pulse("R5 capture"); run_frame(1, 0);
      load(12'h800); conv_pulse("R5 capture"); run_frame(0, 0);
      // power runs: R7 nap at 2,3, R8 sleep at 4 and 5
      load(12'h3C3);
      conv_pulse("R7 run1");
      conv_pulse("R7 nap run2");
      conv_pulse("R7 nap run3");
      load(12'h1E1);
      conv_pulse("R8 sleep run4");
      load(12'h777);
      conv_pulse("R8 sleep run5");
      // R9: clock edge alone leaves flags
      sck_pulse(2);
      chk(sleep === 1'b1 && nap === 1'b0, "R9 flags held after sck", {nap, sleep}, 1);
      // wake: flags clear, R10 sent word is the one captured before sleep (3C3)
      conv_pulse("R9 wake");
      run_frame(0, 0);
      conv_pulse("R10 after sleep");
      chk(m_tx == 12'h777, "R10 model", m_tx, 12'h777);
      run_frame(0, 0);
      // nap then wake through one sck
      conv_pulse("R7 run1 again");
      conv_pulse("R7 nap again");
      sck_pulse(0);
      chk(nap === 1'b1, "R9 nap held after sck", nap, 1);
      conv_pulse("R9 nap cleared");
      run_frame(2, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule